// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one pulse-width-modulation channel. A free-running prescaler divides the system clock into count ticks. An up-counter advances on those ticks while the channel runs. The counter is compared against a cycle value and a duty value to shape a single waveform pin. Software reaches the channel through a plain register write/read port. There is no streaming data path, so the port has no valid/ready handshake: a write takes effect on the clock edge where `wr_en` is high, and `rdata` follows `addr` combinationally.

Register addresses:

| Address | Contents |
|---|---|
| 0 | Run bit (bit 0) |
| 1 | Prescale divisor |
| 2 | Extra clock division select (bits 1:0) |
| 3 | Mode (bit 0 = single-period mode) |
| 4 | Counter |
| 5 | Cycle value |
| 6 | Duty value |

The prescale divisor, the clock select and the mode are configuration. They only accept writes while the run bit is 0. After each accepted prescale write, the prescaler needs a fixed settling interval before the channel may be started. The `ready_o` pin reports that this interval has ended.

Stopping the channel freezes the counter and keeps every register. The waveform pin holds the level it had when the channel stopped. When the channel starts, the first prescaler tick only aligns the counter to the tick phase. For this reason, the first period after a start can be up to one tick longer than programmed. Every period after that is exact.

Top module: `pwm_chan`

## Requirements
- R1: After reset the run bit reads 0, the counter reads 0, `wave_o` is low and `ready_o` is low.
- R2: An accepted write to address 1 drives `ready_o` low for exactly SETTLE (default 32) clock cycles. A write of 1 to the run bit while `ready_o` is low is ignored.
- R3: While the run bit is 1, writes to addresses 1, 2 and 3 are ignored, and their read-back values do not change.
- R4: A count tick occurs every (P+1)·2^S clocks, where P is the prescale value and S is address 2 bits 1:0. The counter advances by one per tick, and only while the run bit is 1.
- R5: When the counter's next value equals the duty value, `wave_o` goes low. When it equals the cycle value, `wave_o` goes high and the counter returns to 0. The period is therefore C ticks, and the output is high for D ticks.
- R6: With the duty value at least the cycle value, `wave_o` stays high for the whole period.
- R7: Clearing the run bit stops the counter. The counter, the cycle and duty registers, and `wave_o` all keep their values while the channel is halted.
- R8: After a start, the first tick does not advance the counter. With the counter at 0, the first cycle match therefore lands between C·T+1 and (C+1)·T clocks after the start write, where T is the tick period. Later periods are exactly C·T.
- R9: With mode bit 0 set, a cycle match clears the run bit. This leaves the counter at 0 and `wave_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr` |
| ready_o | output | 1 | Prescaler settled; start allowed |
| run_o | output | 1 | Current run bit |
| wave_o | output | 1 | PWM waveform |

## Verification
The assertions check the following on every cycle:
- Configuration registers never change while the channel runs.
- The counter and the waveform stay frozen while the channel is halted.
- A start never happens without `ready_o`.
- `ready_o` drops after an accepted prescale write.
- A single-period stop always leaves the output high.

Only the directed scenarios can show the rest:
- The exact 32-cycle settling length.
- The duty ratio under different prescale and division settings.
- The bounded stretch of the first period after a start.
- The constant-high output for large duty values.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] RA_RUN    = 3'd0;
  localparam logic [ADDR_W-1:0] RA_PRESC  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CLKSEL = 3'd2;
  localparam logic [ADDR_W-1:0] RA_MODE   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_COUNT  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CYCLE  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_DUTY   = 3'd6;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              ready,
  input  logic              stop_req,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              run,
  output logic [PSC_W-1:0]  psc,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              one_shot,
  output logic [CNT_W-1:0]  cyc,
  output logic [CNT_W-1:0]  duty,
  output logic              psc_load,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  rdata
);
  // configuration writes are only accepted while stopped
  logic cfg_open;
  assign cfg_open = wr_en && !run;
  assign psc_load = cfg_open && (addr == RA_PRESC);
  assign cnt_load = wr_en && (addr == RA_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      psc      <= '0;
      clk_sel  <= '0;
      one_shot <= 1'b0;
      cyc      <= '0;
      duty     <= '0;
    end else begin
      if (wr_en && addr == RA_RUN) begin
        run <= wdata[0] && ready;
      end else if (stop_req) begin
        run <= 1'b0;
      end
      if (psc_load) psc <= wdata[PSC_W-1:0];
      if (cfg_open && addr == RA_CLKSEL) clk_sel <= wdata[SEL_W-1:0];
      if (cfg_open && addr == RA_MODE) one_shot <= wdata[0];
      if (wr_en && addr == RA_CYCLE) cyc <= wdata;
      if (wr_en && addr == RA_DUTY) duty <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_RUN:    rdata = {{(CNT_W-1){1'b0}}, run};
      RA_PRESC:  rdata = {{(CNT_W-PSC_W){1'b0}}, psc};
      RA_CLKSEL: rdata = {{(CNT_W-SEL_W){1'b0}}, clk_sel};
      RA_MODE:   rdata = {{(CNT_W-1){1'b0}}, one_shot};
      RA_COUNT:  rdata = cnt_val;
      RA_CYCLE:  rdata = cyc;
      RA_DUTY:   rdata = duty;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_chan_presc.sv
module pwm_chan_presc #(
  parameter int PSC_W  = 8,
  parameter int SEL_W  = 2,
  parameter int SETTLE = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psc_load,
  input  logic [PSC_W-1:0] psc,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick,
  output logic             ready
);
  localparam int DC_W  = (1 << SEL_W) - 1;
  localparam int SET_W = $clog2(SETTLE + 1);

  logic [PSC_W-1:0] base_cnt;
  logic [DC_W-1:0]  div_cnt;
  logic [DC_W-1:0]  div_mask;
  logic [SET_W-1:0] settle_cnt;
  logic             base_hit;

  assign base_hit = (base_cnt == psc);

  // one mask bit per power of two in the secondary divider
  for (genvar i = 0; i < DC_W; i++) begin : g_mask
    assign div_mask[i] = (i < int'(clk_sel));
  end

  assign tick  = base_hit && ((div_cnt & div_mask) == div_mask);
  assign ready = (settle_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || psc_load) begin
      base_cnt   <= '0;
      div_cnt    <= '0;
      settle_cnt <= SET_W'(SETTLE);
    end else begin
      base_cnt <= base_hit ? '0 : base_cnt + 1'b1;
      if (base_hit) div_cnt <= div_cnt + 1'b1;
      if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] duty,
  input  logic             one_shot,
  output logic [CNT_W-1:0] cnt,
  output logic             wave,
  output logic             stop_req
);
  logic             armed;
  logic             adv;
  logic [CNT_W-1:0] nxt;
  logic             cyc_hit;
  logic             duty_hit;

  assign nxt      = cnt + 1'b1;
  assign adv      = tick && run && armed && !cnt_load;
  assign cyc_hit  = (nxt == cyc);
  assign duty_hit = (nxt == duty);
  assign stop_req = adv && cyc_hit && one_shot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      wave  <= 1'b0;
      armed <= 1'b0;
    end else begin
      // first tick after a start only aligns to the tick phase
      if (!run) armed <= 1'b0;
      else if (tick) armed <= 1'b1;
      if (cnt_load) cnt <= load_val;
      else if (adv) cnt <= cyc_hit ? '0 : nxt;
      if (adv) begin
        if (cyc_hit) wave <= 1'b1;
        else if (duty_hit) wave <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int SEL_W  = 2,
  parameter int SETTLE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              ready_o,
  output logic              run_o,
  output logic              wave_o
);
  logic [PSC_W-1:0] psc_val;
  logic [SEL_W-1:0] sel_val;
  logic             one_shot;
  logic [CNT_W-1:0] cyc_val;
  logic [CNT_W-1:0] duty_val;
  logic [CNT_W-1:0] cnt_val;
  logic             psc_load;
  logic             cnt_load;
  logic             tick;
  logic             stop_req;

  pwm_chan_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(ready_o), .stop_req(stop_req), .cnt_val(cnt_val),
    .run(run_o), .psc(psc_val), .clk_sel(sel_val), .one_shot(one_shot),
    .cyc(cyc_val), .duty(duty_val), .psc_load(psc_load),
    .cnt_load(cnt_load), .rdata(rdata)
  );

  pwm_chan_presc #(.PSC_W(PSC_W), .SEL_W(SEL_W), .SETTLE(SETTLE)) u_presc (
    .clk(clk), .rst(rst), .psc_load(psc_load), .psc(psc_val),
    .clk_sel(sel_val), .tick(tick), .ready(ready_o)
  );

  pwm_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .run(run_o), .cnt_load(cnt_load),
    .load_val(wdata), .cyc(cyc_val), .duty(duty_val), .one_shot(one_shot),
    .cnt(cnt_val), .wave(wave_o), .stop_req(stop_req)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8,
  parameter int SEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              run,
  input logic              ready,
  input logic              wave,
  input logic [CNT_W-1:0]  cnt,
  input logic [PSC_W-1:0]  psc,
  input logic [SEL_W-1:0]  sel,
  input logic              one_shot
);
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
    $past(run) |-> ($stable(psc) && $stable(sel) && $stable(one_shot)));

  assert_start_ready_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(ready));

  assert_settle_low_R2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && addr == RA_PRESC && !run) |-> !ready);

  assert_hold_wave_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> $stable(wave));

  assert_hold_cnt_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(wr_en && addr == RA_COUNT)) |-> $stable(cnt));

  assert_oneshot_high_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(run) && !$past(wr_en && addr == RA_RUN)) |-> wave);
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .run(run_o),
  .ready(ready_o), .wave(wave_o), .cnt(cnt_val), .psc(psc_val),
  .sel(sel_val), .one_shot(one_shot)
);

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ready_o, run_o, wave_o;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwm_chan u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
               .rdata(rdata), .ready_o(ready_o), .run_o(run_o), .wave_o(wave_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 500 && !ready_o; n++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wave_o) h++;
    end
  endtask

  task automatic t_reset();
    int v;
    rd(4, v);
    chk("R1 counter", v, 0);
    rd(0, v);
    chk("R1 run bit", v, 0);
    chk("R1 wave", int'(wave_o), 0);
    chk("R1 ready", int'(ready_o), 0);
  endtask

  task automatic t_settle();
    int n, v;
    wait_ready();
    wr(1, 3);
    n = 0;
    while (!ready_o && n < 100) begin n++; @(negedge clk); end
    chk("R2 settle length", n, 32);
    wr(1, 3);
    wr(0, 1);
    rd(0, v);
    chk("R2 start ignored while settling", v, 0);
    wait_ready();
  endtask

  task automatic t_first_period();
    int j, h, l;
    wr(5, 4);
    wr(6, 2);
    wr(0, 1);
    j = 0;
    while (!wave_o && j < 100) begin @(negedge clk); j++; end
    chk("R8 first match window", int'(j >= 17 && j <= 20), 1);
    h = 0;
    while (wave_o && h < 100) begin @(negedge clk); h++; end
    l = 0;
    while (!wave_o && l < 100) begin @(negedge clk); l++; end
    chk("R5 high time", h, 8);
    chk("R8 later period exact", h + l, 16);
  endtask

  task automatic t_locked();
    int v;
    wr(1, 9);
    wr(2, 3);
    wr(3, 1);
    rd(1, v); chk("R3 prescale locked", v, 3);
    rd(2, v); chk("R3 clock select locked", v, 0);
    rd(3, v); chk("R3 mode locked", v, 0);
    chk("R3 ready kept", int'(ready_o), 1);
  endtask

  task automatic t_halt();
    int c1, c2, w1, v;
    wr(0, 0);
    rd(4, c1);
    w1 = int'(wave_o);
    repeat (20) @(negedge clk);
    rd(4, c2);
    chk("R7 counter frozen", c2, c1);
    chk("R7 wave held", int'(wave_o), w1);
    rd(5, v); chk("R7 cycle kept", v, 4);
    rd(6, v); chk("R7 duty kept", v, 2);
    chk("R4 no count while stopped", c2, c1);
  endtask

  task automatic t_ratio();
    int h;
    wr(1, 0);
    wait_ready();
    wr(5, 10); wr(6, 3); wr(4, 0); wr(0, 1);
    repeat (30) @(negedge clk);
    count_high(100, h);
    chk("R5 duty 3 of 10", h, 30);
  endtask

  task automatic t_divider();
    int h;
    wr(0, 0);
    wr(1, 1); wr(2, 1);
    wait_ready();
    wr(5, 5); wr(6, 2); wr(4, 0); wr(0, 1);
    repeat (60) @(negedge clk);
    count_high(200, h);
    chk("R4 tick every 4 clocks", h, 80);
  endtask

  task automatic t_full_high();
    int h;
    wr(6, 5);
    repeat (40) @(negedge clk);
    count_high(60, h);
    chk("R6 duty equals cycle", h, 60);
    wr(6, 9);
    repeat (40) @(negedge clk);
    count_high(60, h);
    chk("R6 duty above cycle", h, 60);
  endtask

  task automatic t_oneshot();
    int v;
    wr(0, 0);
    wr(3, 1); wr(2, 0); wr(1, 0);
    wait_ready();
    wr(5, 6); wr(6, 2); wr(4, 0); wr(0, 1);
    repeat (30) @(negedge clk);
    rd(0, v); chk("R9 run cleared", v, 0);
    rd(4, v); chk("R9 counter zero", v, 0);
    chk("R9 wave high", int'(wave_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_settle();
    t_first_period();
    t_locked();
    t_halt();
    t_ratio();
    t_divider();
    t_full_high();
    t_oneshot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule